// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog

This block is a register-mapped watchdog with a 10-bit down-counter. The counter steps once per tick strobe. Software keeps it alive by writing a reload command to the count register, which copies the programmed initial value back into the counter. A tick period of 0.6 s is assumed, so a timeout of S seconds takes S*10/6 ticks.

Expiry happens in two stages. When the counter first runs out, the block raises a timeout flag and starts counting again from the initial value. Nothing else happens at that point. If the counter runs out a second time while that flag is still set, the block sends out a one-clock reset request and records a second-timeout flag and a boot flag. An external no-reboot input holds the reset request back. A halt control bit freezes the counter.

The stage is held in a two-state machine:
- `ST_ARMED`: the timeout flag is clear.
- `ST_WARNED`: the timeout flag is set.

Its transitions are:
- `ARMED->WARNED` on an expiry.
- `WARNED->WARNED` (fire) on an expiry.
- `WARNED->ARMED` on a write of 1 to the flag.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the halt bit reads 1, both status registers read 0, the initial-value register reads 0x0004, the count reads 4 and `rst_req_o` is 0.
- R2: While not halted, each tick lowers the count by one. A read of address 0 returns the live count in bits [9:0], with the other bits 0.
- R3: Bit 11 of the control register (address 2) is the halt bit and reads back as written. While it is 1, ticks leave the count unchanged.
- R4: At the initial-value register (address 1), a write whose bits [9:0] are below 4 is ignored completely. Any other write stores the whole 16-bit word, which then reads back unchanged. Bits [9:0] are the reload value.
- R5: Writing exactly 0x0001 to address 0 loads the count from the initial value. Any other value written there has no effect. A reload and a tick in the same cycle give a reload.
- R6: A tick at count 0 (not halted) is an expiry, and the count reloads from the initial value. The first expiry sets bit 3 of status register 1 (address 3) and requests no reset.
- R7: An expiry while bit 3 of status register 1 is set makes `rst_req_o` high for exactly one cycle, starting at the following clock edge. It also sets bit 1 (second timeout) and bit 2 (boot) of status register 2 (address 4). Bit 3 stays set.
- R8: Bit 3 of status register 1 is cleared by writing 1 to it; writing 0 leaves it. Once it is cleared, the next expiry only sets it again, with no reset request.
- R9: Bits 1 and 2 of status register 2 are each cleared by writing 1 to them.
- R10: While `no_reboot_i` is 1, a second expiry gives no reset pulse and leaves the boot bit clear, but it still sets the second-timeout bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for `addr_i` (combinational) |
| tick_i | input | 1 | Count strobe, one cycle per tick |
| no_reboot_i | input | 1 | 1 blocks the reset request |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A stage register stuck in `ST_ARMED` shows up in two ways: status register 1 reads 0 right after the first expiry, and no reset pulse follows a full second countdown. A stage register stuck in `ST_WARNED` shows up as a pulse on the very first expiry. A counter that steps while halted, or that reloads on the wrong write value, gives a wrong count on the next read. That read comes within one tick. Errors in the flag gating or the pulse width appear on `rst_req_o` in the cycle after the second expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    parameter int unsigned DATA_W = 16;
    parameter int unsigned CNT_W  = 10;
    parameter int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
    localparam logic [ADDR_W-1:0] A_INIT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT1 = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT2 = 3'd4;

    localparam int HALT_BIT = 11;
    localparam int TOUT_BIT = 3;
    localparam int STO_BIT  = 1;
    localparam int BOOT_BIT = 2;
    localparam int INIT_MIN = 4;

    typedef enum logic {
        ST_ARMED  = 1'b0,
        ST_WARNED = 1'b1
    } stage_e;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned INIT_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             halt_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] init_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             step;

    // a reload in the same cycle wins over a tick
    assign step     = tick_i & ~halt_i & ~reload_i;
    assign expire_o = step && (cnt_q == '0);
    assign count_o  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(INIT_MIN);
        end else if (reload_i) begin
            cnt_q <= init_i;
        end else if (step) begin
            if (cnt_q == '0) cnt_q <= init_i;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdog_stage_fsm.sv
module wdog_stage_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clr_warn_i,
    input  logic no_reboot_i,
    output logic warned_o,
    output logic fire_o,
    output logic rst_req_o
);
    stage_e st_q, st_d;
    logic   req_q;

    // next-state process
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ARMED:  if (expire_i) st_d = ST_WARNED;
            ST_WARNED: if (!expire_i && clr_warn_i) st_d = ST_ARMED;
        endcase
    end

    // output process
    always_comb begin
        fire_o = 1'b0;
        unique case (st_q)
            ST_ARMED:  fire_o = 1'b0;
            ST_WARNED: fire_o = expire_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_ARMED;
            req_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            req_q <= fire_o & ~no_reboot_i;
        end
    end

    assign warned_o  = (st_q == ST_WARNED);
    assign rst_req_o = req_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned CW = 10,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o,
    input  logic [CW-1:0] count_i,
    input  logic          warned_i,
    input  logic          fire_i,
    input  logic          no_reboot_i,
    output logic          halt_o,
    output logic [CW-1:0] init_o,
    output logic          reload_o,
    output logic          clr_warn_o
);
    logic [DW-1:0] init_q;
    logic          halt_q, sto_q, boot_q;
    logic          hit_init, hit_ctrl, hit_stat2;

    assign hit_init  = wr_en_i && (addr_i == A_INIT);
    assign hit_ctrl  = wr_en_i && (addr_i == A_CTRL);
    assign hit_stat2 = wr_en_i && (addr_i == A_STAT2);

    assign reload_o   = wr_en_i && (addr_i == A_COUNT) && (wr_data_i == DW'(1));
    assign clr_warn_o = wr_en_i && (addr_i == A_STAT1) && wr_data_i[TOUT_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= DW'(INIT_MIN);
            halt_q <= 1'b1;
            sto_q  <= 1'b0;
            boot_q <= 1'b0;
        end else begin
            if (hit_init && (wr_data_i[CW-1:0] >= CW'(INIT_MIN)))
                init_q <= wr_data_i;
            if (hit_ctrl)
                halt_q <= wr_data_i[HALT_BIT];
            sto_q  <= (sto_q  & ~(hit_stat2 & wr_data_i[STO_BIT]))  | fire_i;
            boot_q <= (boot_q & ~(hit_stat2 & wr_data_i[BOOT_BIT])) | (fire_i & ~no_reboot_i);
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (addr_i)
            A_COUNT: rd_data_o[CW-1:0]  = count_i;
            A_INIT:  rd_data_o          = init_q;
            A_CTRL:  rd_data_o[HALT_BIT] = halt_q;
            A_STAT1: rd_data_o[TOUT_BIT] = warned_i;
            A_STAT2: begin
                rd_data_o[STO_BIT]  = sto_q;
                rd_data_o[BOOT_BIT] = boot_q;
            end
            default: rd_data_o = '0;
        endcase
    end

    assign halt_o = halt_q;
    assign init_o = init_q[CW-1:0];
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
    import wdog_pkg::*;
#(
    parameter int unsigned DW = wdog_pkg::DATA_W,
    parameter int unsigned CW = wdog_pkg::CNT_W,
    parameter int unsigned AW = wdog_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o,
    input  logic          tick_i,
    input  logic          no_reboot_i,
    output logic          rst_req_o
);
    logic [CW-1:0] count, init_val;
    logic          halt, reload, clr_warn, expire, warned, fire;

    wdog_regs #(.DW(DW), .CW(CW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr_i(addr_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
        .count_i(count), .warned_i(warned), .fire_i(fire), .no_reboot_i(no_reboot_i),
        .halt_o(halt), .init_o(init_val), .reload_o(reload), .clr_warn_o(clr_warn)
    );

    wdog_counter #(.CNT_W(CW), .INIT_MIN(INIT_MIN)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .halt_i(halt), .reload_i(reload),
        .init_i(init_val), .count_o(count), .expire_o(expire)
    );

    wdog_stage_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .expire_i(expire), .clr_warn_i(clr_warn),
        .no_reboot_i(no_reboot_i), .warned_o(warned), .fire_o(fire), .rst_req_o(rst_req_o)
    );
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
    parameter int unsigned CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rst_req,
    input logic          no_reboot,
    input logic          warned,
    input logic          halt,
    input logic          reload,
    input logic [CW-1:0] count,
    input logic [CW-1:0] init_val
);
    // R7
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R10
    req_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(no_reboot));
    // R7
    req_needs_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(warned));
    // R3
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> (count == $past(count)));
    // R4
    init_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_val >= CW'(4));
endmodule

bind wdog_twostage wdog_twostage_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req_o), .no_reboot(no_reboot_i),
    .warned(warned), .halt(halt), .reload(reload), .count(count), .init_val(init_val)
);

// File: tb/tb_wdog_twostage.sv
module tb_wdog_twostage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        tick = 1'b0;
    logic        no_reboot = 1'b0;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string exp_q[$];
    logic  req_prev = 1'b0;

    always #10 clk = ~clk;

    wdog_twostage dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wdata),
        .rd_data_o(rdata), .tick_i(tick), .no_reboot_i(no_reboot), .rst_req_o(rst_req)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [15:0] exp);
        @(negedge clk);
        addr = a;
        #1 chk(tag, rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    // monitor: every reset pulse must match one expected item, one cycle wide
    always @(negedge clk) begin
        if (rst_n && rst_req) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10/R8: actual unexpected reset pulse expected none");
            end else begin
                void'(exp_q.pop_front());
            end
            if (req_prev) begin
                errors++;
                $display("FAIL R7: actual pulse wider than 1 cycle expected 1 cycle");
            end
        end
        req_prev = rst_req;
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd_chk("R1 ctrl", 3'd2, 16'h0800);
        rd_chk("R1 stat1", 3'd3, 16'h0000);
        rd_chk("R1 stat2", 3'd4, 16'h0000);
        rd_chk("R1 init", 3'd1, 16'h0004);
        rd_chk("R1 count", 3'd0, 16'h0004);
        chk("R1 rst_req", {15'd0, rst_req}, 16'h0000);
        // R4 illegal and legal initial values
        wr(3'd1, 16'h0002);
        rd_chk("R4 illegal ignored", 3'd1, 16'h0004);
        wr(3'd1, 16'hA805);
        rd_chk("R4 readback", 3'd1, 16'hA805);
        wr(3'd1, 16'hFC03);
        rd_chk("R4 illegal keeps", 3'd1, 16'hA805);
        // R3 halted counter ignores ticks
        ticks(3);
        rd_chk("R3 halted count", 3'd0, 16'h0004);
        // R5 reload
        wr(3'd0, 16'h0001);
        rd_chk("R5 reload", 3'd0, 16'h0005);
        wr(3'd2, 16'h0000);
        rd_chk("R3 halt clear", 3'd2, 16'h0000);
        // R2 decrement
        ticks(2);
        rd_chk("R2 decrement", 3'd0, 16'h0003);
        wr(3'd0, 16'h0000);
        rd_chk("R5 non-one ignored", 3'd0, 16'h0003);
        // R5 reload wins over tick
        @(negedge clk);
        addr = 3'd0; wdata = 16'h0001; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd_chk("R5 reload priority", 3'd0, 16'h0005);
        // R6 first expiry
        ticks(6);
        rd_chk("R6 stat1 set", 3'd3, 16'h0008);
        rd_chk("R6 count reloaded", 3'd0, 16'h0005);
        rd_chk("R6 no stat2", 3'd4, 16'h0000);
        // R8 writing 0 leaves flag
        wr(3'd3, 16'h0000);
        rd_chk("R8 write0 keeps", 3'd3, 16'h0008);
        // R7 second expiry
        exp_q.push_back("R7");
        ticks(6);
        rd_chk("R7 stat2", 3'd4, 16'h0006);
        rd_chk("R7 stat1 kept", 3'd3, 16'h0008);
        rd_chk("R7 count reloaded", 3'd0, 16'h0005);
        // R9 clear stat2
        wr(3'd4, 16'h0006);
        rd_chk("R9 stat2 cleared", 3'd4, 16'h0000);
        // R8 clear and restart sequence
        wr(3'd3, 16'h0008);
        rd_chk("R8 cleared", 3'd3, 16'h0000);
        ticks(6);
        rd_chk("R8 restart stat1", 3'd3, 16'h0008);
        rd_chk("R8 restart no reset", 3'd4, 16'h0000);
        // R10 no-reboot gate
        no_reboot = 1'b1;
        ticks(6);
        rd_chk("R10 sto only", 3'd4, 16'h0002);
        no_reboot = 1'b0;
        // R3 halt again
        wr(3'd2, 16'h0800);
        rd_chk("R3 halt readback", 3'd2, 16'h0800);
        ticks(2);
        rd_chk("R3 halt freeze", 3'd0, 16'h0005);
        repeat (3) @(negedge clk);
        chk("R7 pulses consumed", 16'(exp_q.size()), 16'h0000);
        done = 1'b1;
        finish_run();
    end
endmodule